// File: doc/BRIEF.md
# Dual-Mode Full-Bridge PWM Modulator

This block turns a signed modulation command into gate requests for the two half-bridge legs of a full bridge. Each leg has a high-side and a low-side output. The two outputs of a leg are never on together, and they are separated by a programmable number of idle clocks whenever the leg's requested state changes. An up-counting carrier sets the switching period. The command is limited in magnitude to a programmable maximum duty and converted to a single compare value shared by both legs.

Two switching schemes are offered. In the bipolar scheme both legs switch on every period, and leg B has the opposite sense to leg A. In the unipolar scheme only one leg switches. The sign of the command picks that leg, and the other leg is parked with its low side on. A fault input, or a mode selection that is neither scheme, stops the bridge with all four gates off. The period, the command and the scheme are loaded together when the carrier wraps, so a period is never built from mixed settings. A one-clock trigger pulse is issued at a fixed early count in every period, so that an external converter can sample the phase currents there.

Top module: `hbridge_pwm`

## Requirements
- R1: The carrier counts 0, 1, ..., P-1 and then returns to 0, one step per clock. P is the `period` input captured on the clock where the count returns to 0, and a `period` below 2 is taken as 2. After reset the count is 0 and P is 2.
- R2: The command `cmd` (signed Q1.15) is limited to the range -`max_duty` to +`max_duty` before use, with `max_duty` unsigned Q0.15. A command of -32768 with a limit of 32767 gives -32767.
- R3: With `mode_sel` = 1 (bipolar), the compare value is floor(P × (m + 32768) / 65536), where m is the limited command. Leg A requests its high side while count < compare and its low side otherwise. Leg B requests its high side while count ≥ compare and its low side otherwise.
- R4: With `mode_sel` = 2 (unipolar), the compare value is floor(P × |m| / 32768). For m ≥ 0, leg A switches as in R3 while leg B requests only its low side. For m < 0, leg B switches with the sense leg A has in R3, and leg A requests only its low side.
- R5: When a leg's requested state changes, both outputs of that leg go low on that clock. They stay low until the new request has been unchanged for `dead_time`+2 consecutive clocks. A leg's high and low outputs are never both high.
- R6: When `fault` is 1, or `mode_sel` is 0 or 3, the outputs are forced to all low on the next clock. Commands are not applied while that condition holds. Switching resumes only at the next carrier wrap after the condition clears. Reset also leaves all outputs low.
- R7: `adc_trig` is high for exactly the clock on which the carrier count equals 200, and never high when P ≤ 200.
- R8: Changes to `cmd`, `max_duty` and `mode_sel` between stop-free wraps take effect only on the clock where the count returns to 0. A stop request is the exception, because it acts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 none, 1 bipolar, 2 unipolar, 3 none |
| fault | input | 1 | Forces the stopped state |
| period | input | 16 | Carrier period in clocks |
| cmd | input | 16 | Signed Q1.15 modulation command |
| max_duty | input | 15 | Unsigned Q0.15 magnitude limit |
| dead_time | input | 8 | Dead-time length setting |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |
| adc_trig | output | 1 | Sampling trigger pulse |

## Verification
The bench drives commands that change in the middle of a period, sign reversals in the unipolar scheme, and the most negative command against a reduced limit. A design that updates the compare value at once would produce truncated pulses, and a wrong clamp would produce a full-width pulse. Periods below 2 and periods at or below 200 are applied: a design without the period floor would stall, and an unconditional trigger would fire in periods too short to contain it. Dead times of 0, 9 and 255 are applied against short pulses to expose off-by-one gaps and shoot-through. A fault is raised in the middle of a period, and the command is changed while the fault is held, to show that a design which resumed early or latched the command would be caught.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int PER_W = 16;
  localparam int CMD_W = 16;

  localparam logic [1:0] SEL_BIP = 2'd1;
  localparam logic [1:0] SEL_UNI = 2'd2;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_LOW = 2'd1,
    LEG_FWD = 2'd2,
    LEG_REV = 2'd3
  } leg_mode_e;

  function automatic logic signed [CMD_W-1:0] clamp_cmd(
    input logic signed [CMD_W-1:0] c,
    input logic [CMD_W-2:0] lim
  );
    logic signed [CMD_W:0] cx, top, bot;
    cx  = {c[CMD_W-1], c};
    top = $signed({2'b00, lim});
    bot = -top;
    if (cx > top) return top[CMD_W-1:0];
    if (cx < bot) return bot[CMD_W-1:0];
    return c;
  endfunction

  function automatic logic [CMD_W-2:0] mag_of(input logic signed [CMD_W-1:0] m);
    logic signed [CMD_W-1:0] n;
    n = m[CMD_W-1] ? -m : m;
    return n[CMD_W-2:0];
  endfunction

  // floor(P * (m + half_scale) / full_scale): offset binary via MSB flip
  function automatic logic [PER_W-1:0] bip_cmp(
    input logic [PER_W-1:0] p,
    input logic signed [CMD_W-1:0] m
  );
    logic [CMD_W-1:0] off;
    logic [PER_W+CMD_W-1:0] prod;
    off  = {~m[CMD_W-1], m[CMD_W-2:0]};
    prod = (PER_W+CMD_W)'(p) * (PER_W+CMD_W)'(off);
    return prod[PER_W+CMD_W-1:CMD_W];
  endfunction

  // floor(P * |m| / half_scale)
  function automatic logic [PER_W-1:0] uni_cmp(
    input logic [PER_W-1:0] p,
    input logic [CMD_W-2:0] mag
  );
    logic [PER_W+CMD_W-2:0] prod;
    prod = (PER_W+CMD_W-1)'(p) * (PER_W+CMD_W-1)'(mag);
    return prod[PER_W+CMD_W-2:CMD_W-1];
  endfunction
endpackage

// File: rtl/hbp_carrier.sv
module hbp_carrier #(
  parameter int PER_W   = 16,
  parameter int MIN_PER = 2,
  parameter int TRIG_AT = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_in,
  output logic [PER_W-1:0] cnt_q,
  output logic [PER_W-1:0] per_load,
  output logic             wrap,
  output logic             trig
);
  logic [PER_W-1:0] per_q;

  assign per_load = (period_in < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : period_in;
  assign wrap     = (cnt_q == per_q - PER_W'(1));
  assign trig     = (cnt_q == PER_W'(TRIG_AT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= PER_W'(MIN_PER);
    end else if (wrap) begin
      cnt_q <= '0;
      per_q <= per_load;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/hbp_modsel.sv
module hbp_modsel
  import hbp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrap,
  input  logic [1:0]              mode_sel,
  input  logic                    fault,
  input  logic signed [CMD_W-1:0] cmd,
  input  logic [CMD_W-2:0]        max_duty,
  input  logic [PER_W-1:0]        per_load,
  output leg_mode_e               leg_a,
  output leg_mode_e               leg_b,
  output logic [PER_W-1:0]        cmp_q,
  output logic                    stop_req,
  output logic                    load_evt
);
  logic signed [CMD_W-1:0] m_lim;
  logic [PER_W-1:0]        cmp_n;
  leg_mode_e               a_n, b_n;

  assign stop_req = fault | ~((mode_sel == SEL_BIP) | (mode_sel == SEL_UNI));
  assign load_evt = wrap & ~stop_req;

  always_comb begin
    m_lim = clamp_cmd(cmd, max_duty);
    if (mode_sel == SEL_BIP) begin
      cmp_n = bip_cmp(per_load, m_lim);
      a_n   = LEG_FWD;
      b_n   = LEG_REV;
    end else begin
      cmp_n = uni_cmp(per_load, mag_of(m_lim));
      if (m_lim[CMD_W-1]) begin
        a_n = LEG_LOW;
        b_n = LEG_FWD;
      end else begin
        a_n = LEG_FWD;
        b_n = LEG_LOW;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_a <= LEG_OFF;
      leg_b <= LEG_OFF;
      cmp_q <= '0;
    end else if (stop_req) begin
      leg_a <= LEG_OFF;
      leg_b <= LEG_OFF;
    end else if (load_evt) begin
      leg_a <= a_n;
      leg_b <= b_n;
      cmp_q <= cmp_n;
    end
  end
endmodule

// File: rtl/hbp_deadtime.sv
module hbp_deadtime
  import hbp_pkg::*;
#(
  parameter int CW   = 16,
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  leg_mode_e       leg,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   cmp,
  input  logic [DT_W-1:0] dead,
  output logic            hi,
  output logic            lo
);
  logic [1:0]      want, want_q;   // {high request, low request}
  logic [DT_W-1:0] st_q;
  logic            below, settled;

  assign below = (cnt < cmp);

  always_comb begin
    unique case (leg)
      LEG_LOW: want = 2'b01;
      LEG_FWD: want = {below, ~below};
      LEG_REV: want = {~below, below};
      default: want = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_q <= 2'b00;
      st_q   <= '0;
    end else begin
      want_q <= want;
      if (want != want_q)   st_q <= '0;
      else if (st_q != '1)  st_q <= st_q + DT_W'(1);
    end
  end

  assign settled = (want == want_q) && (st_q >= dead);
  assign hi = want[1] & settled;
  assign lo = want[0] & settled;
endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
  import hbp_pkg::*;
#(
  parameter int DT_W    = 8,
  parameter int TRIG_AT = 200,
  parameter int MIN_PER = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_sel,
  input  logic                    fault,
  input  logic [PER_W-1:0]        period,
  input  logic signed [CMD_W-1:0] cmd,
  input  logic [CMD_W-2:0]        max_duty,
  input  logic [DT_W-1:0]         dead_time,
  output logic                    a_hi,
  output logic                    a_lo,
  output logic                    b_hi,
  output logic                    b_lo,
  output logic                    adc_trig
);
  localparam int NUM_LEGS = 2;

  logic [PER_W-1:0]     cnt_q, per_load, cmp_q;
  logic                 wrap, stop_req, load_evt;
  leg_mode_e            leg_st [NUM_LEGS];
  logic [NUM_LEGS-1:0]  hi_w, lo_w;

  hbp_carrier #(.PER_W(PER_W), .MIN_PER(MIN_PER), .TRIG_AT(TRIG_AT)) u_carrier (
    .clk(clk), .rst_n(rst_n), .period_in(period), .cnt_q(cnt_q),
    .per_load(per_load), .wrap(wrap), .trig(adc_trig)
  );

  hbp_modsel u_modsel (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .mode_sel(mode_sel), .fault(fault),
    .cmd(cmd), .max_duty(max_duty), .per_load(per_load),
    .leg_a(leg_st[0]), .leg_b(leg_st[1]), .cmp_q(cmp_q),
    .stop_req(stop_req), .load_evt(load_evt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbp_deadtime #(.CW(PER_W), .DT_W(DT_W)) u_dt (
      .clk(clk), .rst_n(rst_n), .leg(leg_st[g]), .cnt(cnt_q), .cmp(cmp_q),
      .dead(dead_time), .hi(hi_w[g]), .lo(lo_w[g])
    );
  end

  assign a_hi = hi_w[0];
  assign a_lo = lo_w[0];
  assign b_hi = hi_w[1];
  assign b_lo = lo_w[1];
endmodule

// File: rtl/hbridge_pwm_chk.sv
module hbridge_pwm_chk #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fault,
  input logic             a_hi,
  input logic             a_lo,
  input logic             b_hi,
  input logic             b_lo,
  input logic             adc_trig,
  input logic             wrap,
  input logic             stop_req,
  input logic [PER_W-1:0] cnt_q,
  input logic [1:0]       leg_a,
  input logic [1:0]       leg_b
);
  // R5: no shoot-through on either leg
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi && a_lo) && !(b_hi && b_lo));

  // R5: a rising gate always follows a clock with its partner off
  p_gap_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_hi) || $rose(a_lo)) |-> !$past(a_hi && a_lo) && (a_hi ? !$past(a_lo) : !$past(a_hi)));
  p_gap_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_hi) || $rose(b_lo)) |-> (b_hi ? !$past(b_lo) : !$past(b_hi)));

  // R6: fault turns every gate off on the next clock
  p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !(a_hi || a_lo || b_hi || b_lo));

  // R8: leg states only move on a wrap or a stop request
  p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !stop_req) |=> $stable(leg_a) && $stable(leg_b));

  // R4: leg A never takes the inverted sense, and the legs never both take the direct sense
  p_leg_roles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_a != 2'd3) && !(leg_a == 2'd2 && leg_b == 2'd2));

  // R1: a wrap returns the count to zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R7: trigger lasts one clock
  p_trig_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);
endmodule

bind hbridge_pwm hbridge_pwm_chk #(.PER_W(hbp_pkg::PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .adc_trig(adc_trig),
  .wrap(wrap), .stop_req(stop_req), .cnt_q(cnt_q),
  .leg_a(leg_st[0]), .leg_b(leg_st[1])
);

// File: tb/hbridge_pwm_tb.sv
module hbridge_pwm_tb;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         mode_sel = 2'd0;
  logic               fault = 1'b0;
  logic [15:0]        period = 16'd300;
  logic signed [15:0] cmd = '0;
  logic [14:0]        max_duty = 15'd32767;
  logic [7:0]         dead_time = 8'd2;
  logic a_hi, a_lo, b_hi, b_lo, adc_trig;

  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_en = 1'b0;
  string phase = "reset R6";

  always #(CLK_P/2) clk = ~clk;

  hbridge_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fault(fault),
    .period(period), .cmd(cmd), .max_duty(max_duty), .dead_time(dead_time),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .adc_trig(adc_trig)
  );

  task automatic check(input bit ok, input string what, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %b expected %b ({a_hi,a_lo,b_hi,b_lo,trig})", what, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  // leg codes: 0 stopped, 1 low side parked, 2 direct sense, 3 inverted sense
  int m_cnt, m_per, m_cmp, m_la, m_lb;

  always @(posedge clk) begin : mdl
    bit     stop, wr;
    longint pl, mc, lim;
    if (!rst_n) begin
      m_cnt = 0; m_per = 2; m_cmp = 0; m_la = 0; m_lb = 0;
    end else begin
      stop = fault || !(mode_sel == 2'd1 || mode_sel == 2'd2);
      wr   = (m_cnt == m_per - 1);
      pl   = (period < 16'd2) ? 2 : longint'(period);
      if (stop) begin
        m_la = 0; m_lb = 0;
      end else if (wr) begin
        lim = longint'(max_duty);
        mc  = longint'(cmd);
        if (mc > lim)  mc = lim;
        if (mc < -lim) mc = -lim;
        if (mode_sel == 2'd1) begin
          m_cmp = int'((pl * (mc + 32768)) / 65536);
          m_la = 2; m_lb = 3;
        end else begin
          m_cmp = int'((pl * (mc < 0 ? -mc : mc)) / 32768);
          if (mc < 0) begin m_la = 1; m_lb = 2; end
          else        begin m_la = 2; m_lb = 1; end
        end
      end
      if (wr) begin m_cnt = 0; m_per = int'(pl); end
      else m_cnt = m_cnt + 1;
    end
  end

  function automatic logic [1:0] want_of(input int lg, input int c, input int cv);
    case (lg)
      1: return 2'b01;
      2: return (c < cv) ? 2'b10 : 2'b01;
      3: return (c < cv) ? 2'b01 : 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  logic [1:0] pa, pb;
  int ra, rb;

  always @(negedge clk) begin : cmpr
    logic [1:0] wa, wb;
    logic [4:0] exp_v, got_v;
    int need;
    if (!rst_n) begin
      pa = 2'b00; pb = 2'b00; ra = 2; rb = 2;
    end else begin
      wa = want_of(m_la, m_cnt, m_cmp);
      wb = want_of(m_lb, m_cnt, m_cmp);
      if (wa == pa) ra++; else ra = 1;
      if (wb == pb) rb++; else rb = 1;
      pa = wa; pb = wb;
      need = int'(dead_time) + 2;
      exp_v = {wa[1] && ra >= need, wa[0] && ra >= need,
               wb[1] && rb >= need, wb[0] && rb >= need, m_cnt == 200};
      got_v = {a_hi, a_lo, b_hi, b_lo, adc_trig};
      if (chk_en) check(got_v === exp_v, phase, got_v, exp_v);
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    run(5);
    @(negedge clk);
    check({a_hi, a_lo, b_hi, b_lo, adc_trig} === 5'b0, "R6 reset state all low",
          {a_hi, a_lo, b_hi, b_lo, adc_trig}, 5'b0);
    run(1);
    rst_n = 1'b1;
    chk_en = 1'b1;

    phase = "R1 carrier period 300";
    mode_sel = 2'd1; period = 16'd300; cmd = 16'sd0;
    run(1200);
    phase = "R7 no trigger at period 150";
    period = 16'd150;
    run(800);
    phase = "R1 period floor at 1";
    period = 16'd1;
    run(50);
    phase = "R1 period floor at 0";
    period = 16'd0;
    run(20);
    phase = "R7 trigger at period 500";
    period = 16'd500;
    run(1500);

    phase = "R3 bipolar positive";
    cmd = 16'sd10000;
    run(1500);
    phase = "R3 bipolar negative";
    cmd = -16'sd20000;
    run(1500);

    phase = "R2 clamp positive";
    max_duty = 15'd16384; cmd = 16'sd32767;
    run(1100);
    phase = "R2 clamp most negative";
    cmd = -16'sd32768;
    run(1100);
    phase = "R2 clamp zero limit";
    max_duty = 15'd0;
    run(1100);
    phase = "R2 full limit vs -32768";
    max_duty = 15'd32767;
    run(1100);

    phase = "R4 unipolar positive";
    mode_sel = 2'd2; cmd = 16'sd12000;
    run(1100);
    phase = "R4 unipolar negative";
    cmd = -16'sd12000;
    run(1100);
    phase = "R4 unipolar zero";
    cmd = 16'sd0;
    run(1100);

    phase = "R5 dead time 0";
    dead_time = 8'd0; cmd = 16'sd3000;
    run(1100);
    phase = "R5 dead time 9";
    dead_time = 8'd9; cmd = -16'sd3000;
    run(1100);
    phase = "R5 dead time 255";
    dead_time = 8'd255; mode_sel = 2'd1; cmd = 16'sd30000;
    run(1100);
    dead_time = 8'd3;

    phase = "R8 mid-period command changes";
    for (int i = 0; i < 10; i++) begin
      cmd = 16'(i * 6100 - 27000);
      max_duty = 15'(20000 + i * 1200);
      run(137);
    end
    phase = "R8 mid-period mode switches";
    for (int i = 0; i < 8; i++) begin
      mode_sel = (i % 2 == 0) ? 2'd2 : 2'd1;
      cmd = (i % 3 == 0) ? -16'sd9000 : 16'sd14000;
      run(311);
    end

    phase = "R6 fault stop";
    mode_sel = 2'd2; cmd = 16'sd16000; period = 16'd400;
    run(650);
    fault = 1'b1;
    run(300);
    phase = "R6 command ignored while stopped";
    cmd = -16'sd25000;
    run(200);
    phase = "R6 resume after fault";
    fault = 1'b0;
    run(1100);
    phase = "R6 mode none";
    mode_sel = 2'd0;
    run(300);
    phase = "R6 resume from none";
    mode_sel = 2'd2;
    run(1000);
    phase = "R6 mode code 3";
    mode_sel = 2'd3;
    run(300);
    mode_sel = 2'd1;
    run(900);

    chk_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired during %s: got running expected finished", phase);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule